// File: doc/BRIEF.md
# Configurable Sum-of-Products Term Array

This block is the programmable AND plane of a small logic device. It holds a configuration image of connection cells, one per crossing of a product-term row and an array column. It also holds one disable cell per product term and two global mode cells. The image is shifted in one bit per clock while a load strobe is high. Once loading stops, every product term is evaluated combinationally from the current inputs, with no clock involved.

The array has 32 columns, made from 16 signal pairs, each present in true and complement form. It produces 64 product terms, and each group of eight consecutive terms feeds one of eight output macrocells. Half of the pairs come from dedicated inputs. The other half come from feedback slots. What drives each slot depends on the global mode: it can be the macrocell's own feedback, an adjacent macrocell's feedback, or one of two auxiliary pins. In the mode where those two pins act as clock and output enable, they never reach the array. The two mode cells are also exported, so that the macrocells can decode the same mode.

Top module: `pt_array`

## Requirements
- R1: While reset is low and after its release, every cell holds one. With that image all 64 terms read 1 and `mode_o` reads 2'b11.
- R2: Each clock with `ld_en` high shifts `cfg_bit` into the image. After 2114 shifts the first bit sent sits in cell 0 and the last in cell 2113. With `ld_en` low the image, and so `pt_o` and `mode_o` for fixed inputs, does not change whatever `cfg_bit` does.
- R3: Term t uses cells t*32 to t*32+31, one per column, and a cell value 0 connects its column. The term is the AND of its connected columns. Terms 8k to 8k+7 belong to output k. A term connected to both the true and complement column of one pair is always 0.
- R4: A term with no connected column evaluates to 1.
- R5: Cell 2048+t is the disable cell of term t. Programmed to 0, it forces `pt_o[t]` to 0 regardless of the inputs.
- R6: Columns 4i and 4i+1 carry `din[i]` true and complement. Columns 4i+2 and 4i+3 carry feedback slot i true and complement.
- R7: When cell 2112 is 0 (registered mode, either value of cell 2113), slot i is `fb[i]`. `aux_a` and `aux_b` have no effect on any term.
- R8: When cells 2113 and 2112 are 1 and 1 (complex mode), slot 0 is `aux_a`, slot 7 is `aux_b`, and slots 1 to 6 are `fb[1]` to `fb[6]`. `fb[0]` and `fb[7]` have no effect.
- R9: When cell 2113 is 0 and cell 2112 is 1 (simple mode), slot 0 is `aux_a` and slot 7 is `aux_b`. Slots 1 to 3 take `fb[0]` to `fb[2]`, and slots 4 to 6 take `fb[5]` to `fb[7]`. The centre feedbacks `fb[3]` and `fb[4]` have no effect.
- R10: `mode_o[1]` shows cell 2113 and `mode_o[0]` shows cell 2112.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset to the erased image |
| ld_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data |
| din | input | 8 | Dedicated array inputs |
| aux_a | input | 1 | Auxiliary pin A (clock pin in registered mode) |
| aux_b | input | 1 | Auxiliary pin B (enable pin in registered mode) |
| fb | input | 8 | Feedback from the eight macrocells |
| pt_o | output | 64 | Product-term values, eight per output |
| mode_o | output | 2 | Global mode cells for the macrocells |

## Verification
A wrong cell in the image shows at once as a wrong level on the term that owns it, but only under an input pattern that exercises that column. The directed patterns therefore pair each connected column with values that both satisfy and violate it. A misrouted feedback slot only shows up when the wrong source and the right source differ, so each mode is driven with aux and feedback patterns that disagree. A shift-order error moves every cell, and is visible as soon as the first image has been loaded.

// File: rtl/pt_array.sv
module pt_array #(
  parameter int N_OUT = 8,
  parameter int TERMS_PER_OUT = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ld_en,
  input  logic                             cfg_bit,
  input  logic [N_OUT-1:0]                 din,
  input  logic                             aux_a,
  input  logic                             aux_b,
  input  logic [N_OUT-1:0]                 fb,
  output logic [N_OUT*TERMS_PER_OUT-1:0]   pt_o,
  output logic [1:0]                       mode_o
);
  localparam int N_COL     = 4 * N_OUT;
  localparam int N_TERMS   = N_OUT * TERMS_PER_OUT;
  localparam int DIS_BASE  = N_TERMS * N_COL;
  localparam int MODE_BASE = DIS_BASE + N_TERMS;
  localparam int CFG_LEN   = MODE_BASE + 2;
  localparam logic [N_OUT-1:0] CENTRE = N_OUT'(2'b11) << (N_OUT/2 - 1);

  logic [CFG_LEN-1:0] cfg;
  logic [N_OUT-1:0]   s_reg, s_cpx, s_smp, slot;
  logic [N_COL-1:0]   cols;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cfg <= '1;
    else if (ld_en) cfg <= {cfg_bit, cfg[CFG_LEN-1:1]};

  assign mode_o = cfg[MODE_BASE +: 2];

  for (genvar i = 0; i < N_OUT; i++) begin : g_slot
    assign s_reg[i] = fb[i];
    if (i == 0) begin : g_first
      assign s_cpx[i] = aux_a;
      assign s_smp[i] = aux_a;
    end else if (i == N_OUT-1) begin : g_last
      assign s_cpx[i] = aux_b;
      assign s_smp[i] = aux_b;
    end else if (i < N_OUT/2) begin : g_low
      assign s_cpx[i] = fb[i];
      assign s_smp[i] = fb[i-1];
    end else begin : g_high
      assign s_cpx[i] = fb[i];
      assign s_smp[i] = fb[i+1];
    end
    assign cols[4*i +: 4] = {~slot[i], slot[i], ~din[i], din[i]};
  end

  assign slot = !mode_o[0] ? s_reg : (mode_o[1] ? s_cpx : s_smp);

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    assign pt_o[t] = cfg[DIS_BASE + t] & (&(cols | cfg[t*N_COL +: N_COL]));

    assert_disabled_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[DIS_BASE + t] |-> !pt_o[t]);
  end

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && $stable(din) && $stable(fb) && $stable(aux_a) && $stable(aux_b))
      |=> (!$stable(din) || !$stable(fb) || !$stable(aux_a) || !$stable(aux_b)
           || ($stable(pt_o) && $stable(mode_o))));

  assert_reg_aux_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_o[0] && !ld_en)
      |=> (!$stable(din) || !$stable(fb) || $stable(pt_o)));

  assert_cpx_outer_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && !ld_en)
      |=> (!$stable(din) || !$stable(aux_a) || !$stable(aux_b)
           || !$stable(fb[N_OUT-2:1]) || $stable(pt_o)));

  assert_smp_centre_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01 && !ld_en)
      |=> (!$stable(din) || !$stable(aux_a) || !$stable(aux_b)
           || !$stable(fb & ~CENTRE) || $stable(pt_o)));
endmodule

// File: tb/pt_array_tb_top.sv
module pt_array_tb_top;
  localparam int LEN = 2114;
  localparam int DIS = 2048;
  localparam int M0  = 2112;
  localparam int M1  = 2113;

  logic clk = 0, rst_n = 0, ld_en = 0, cfg_bit = 0, aux_a = 0, aux_b = 0;
  logic [7:0] din = 0, fb = 0;
  logic [63:0] pt_o;
  logic [1:0] mode_o;
  logic [LEN-1:0] img;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pt_array dut_i (.clk(clk), .rst_n(rst_n), .ld_en(ld_en), .cfg_bit(cfg_bit),
                  .din(din), .aux_a(aux_a), .aux_b(aux_b), .fb(fb),
                  .pt_o(pt_o), .mode_o(mode_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic conn(input int t, input int c);
    img[t*32 + c] = 1'b0;
  endtask

  task automatic load();
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk); ld_en = 1; cfg_bit = img[i];
    end
    @(negedge clk); ld_en = 0; cfg_bit = 0;
  endtask

  task automatic drive(input logic [7:0] d, input logic [7:0] f, input logic a, input logic b);
    @(negedge clk); din = d; fb = f; aux_a = a; aux_b = b; #1;
  endtask

  task automatic t_reset();
    drive(8'h5A, 8'hC3, 1, 0);
    chk("R1 terms after reset", pt_o, '1);
    chk("R1 mode after reset", {62'd0, mode_o}, 64'd3);
  endtask

  task automatic t_and();
    img = '1; img[M0] = 0;
    conn(0, 0); conn(0, 5); conn(9, 10); conn(63, 0); conn(63, 1);
    load();
    drive(8'h01, 8'h04, 0, 0);
    chk("R3 R4 R6 term true", pt_o, ~64'd0 & ~(64'd1 << 63));
    drive(8'h03, 8'h00, 0, 0);
    chk("R3 R6 term false", pt_o, ~64'd0 & ~(64'd1 << 63) & ~64'd1 & ~(64'd1 << 9));
    drive(8'h00, 8'h00, 1, 1);
    chk("R3 din0 low", pt_o, ~64'd0 & ~(64'd1 << 63) & ~64'd1 & ~(64'd1 << 9));
    chk("R10 mode registered", {62'd0, mode_o}, 64'd2);
  endtask

  task automatic t_disable();
    img[DIS + 0] = 0; img[DIS + 5] = 0;
    load();
    drive(8'h01, 8'h04, 0, 0);
    chk("R5 disabled terms", pt_o, ~64'd0 & ~(64'd1 << 63) & ~64'd1 & ~(64'd1 << 5));
  endtask

  task automatic t_registered();
    img = '1; img[M0] = 0;
    conn(1, 2); conn(2, 30);
    load();
    drive(8'h00, 8'h81, 0, 0);
    chk("R7 fb drives slots", pt_o, '1);
    drive(8'h00, 8'h00, 1, 1);
    chk("R7 aux ignored", pt_o, ~64'd0 & ~64'd6);
  endtask

  task automatic t_complex();
    img = '1;
    conn(1, 2); conn(2, 30); conn(3, 14);
    load();
    chk("R10 mode complex", {62'd0, mode_o}, 64'd3);
    drive(8'h00, 8'h00, 1, 1);
    chk("R8 aux on outer slots", pt_o, ~64'd0 & ~64'd8);
    drive(8'h00, 8'hFF, 0, 0);
    chk("R8 outer fb ignored", pt_o, ~64'd0 & ~64'd6);
  endtask

  task automatic t_simple();
    img = '1; img[M1] = 0;
    conn(1, 2); conn(2, 30); conn(3, 6); conn(4, 14); conn(5, 18); conn(6, 26);
    load();
    chk("R10 mode simple", {62'd0, mode_o}, 64'd1);
    drive(8'h00, 8'h18, 1, 1);
    chk("R9 centre fb ignored", pt_o, ~64'd0 & ~64'h78);
    drive(8'h00, 8'hA5, 0, 0);
    chk("R9 adjacent routing", pt_o, ~64'd0 & ~64'h06);
  endtask

  task automatic t_hold();
    drive(8'h00, 8'hA5, 0, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); cfg_bit = i[0];
    end
    #1;
    chk("R2 hold terms", pt_o, ~64'd0 & ~64'h06);
    chk("R2 hold mode", {62'd0, mode_o}, 64'd1);
    @(negedge clk); rst_n = 0; #1;
    chk("R1 reset clears image", pt_o, '1);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_and();
    t_disable();
    t_registered();
    t_complex();
    t_simple();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule